// File: doc/BRIEF.md
# Video Sync and Blank Level Inserter

This block sits directly behind the input demultiplexer of a triple video DAC front end. On every clock it decides, for each of the three output channels, whether the channel carries pixel data, the blanking level, a negative sync or a positive sync. It outputs a 10-bit code per channel and a 2-bit level tag per channel. The analog stage uses the tag to add or subtract the sync current. The sync-to-video amplitude ratio is applied entirely in that analog stage, outside this block.

Three control inputs are registered on the rising clock edge:
- an active-low sync window,
- an active-low blank,
- an active-high polarity strobe.

The polarity strobe only matters inside a sync window. A low-to-high step on it during the window turns a negative sync into the positive half of a tri-level sync.

Sync wins over blank. The blanking code depends on the colour-space format and on a flag that puts sync on all three channels instead of only the luma/green channel.

The demultiplexer adds latency to the data in its 4:2:2 formats. The control path is therefore given an extra delay chosen by the format, so that level substitution lands on the matching samples.

Top module: `sync_blank_inserter`

## Requirements
- R1: While reset is high, every channel outputs code 0 with tag 01 (blank). The first output after reset is also blank until new controls reach the output.
- R2: Channel n occupies bits [10n+9:10n] of `pix_in` and `code_out`, and bits [2n+1:2n] of `tag_out`. Channel 0 is luma/green, channel 1 is Pb/blue and channel 2 is Pr/red. With sync and blank inactive, a channel outputs the pixel code from two clocks earlier with tag 00 (video).
- R3: With blank active and sync inactive, every channel outputs its blanking code with tag 01.
- R4: With sync active, each channel selected for sync outputs tag 10 or 11 whatever the pixel and blank inputs are. The code on such a channel is its blanking code.
- R5: Inside a sync window, `sync_pos` high gives tag 11 (positive) and low gives tag 10 (negative). A low-to-high step inside the window switches the same window to positive. Outside a window, `sync_pos` has no effect on any output.
- R6: With `ins_all` low, only channel 0 carries sync. During a sync window, channels 1 and 2 output tag 01 with their blanking code.
- R7: With `ins_all` high, all three channels carry the same sync tag during a sync window.
- R8: In format 00 (GBR 4:4:4), the blanking code is 0 on every channel.
- R9: In the YPbPr formats (01 = 4:4:4, 10 = 4:2:2 on two ports, 11 = 4:2:2 on one port), the blanking code depends on `ins_all`. With `ins_all` high it is 0 on channel 0 and 512 on channels 1 and 2. With `ins_all` low it is 0 on every channel.
- R10: In formats 00 and 01, the controls act on the pixel applied in the same clock. In format 10 they act on the pixel applied one clock later, and in format 11 two clocks later. Format and `ins_all` always travel with the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 30 | Three 10-bit channel codes from the demultiplexer |
| sync_n | input | 1 | Sync window, active low |
| blank_n | input | 1 | Blank, active low |
| sync_pos | input | 1 | Sync polarity strobe, high for positive sync |
| fmt | input | 2 | Colour-space / input format select |
| ins_all | input | 1 | Sync on all channels when high, on channel 0 only when low |
| code_out | output | 30 | Three 10-bit output codes |
| tag_out | output | 6 | Three 2-bit level tags for the analog stage |

## Verification
The bench builds the block with its default parameters. These are a 10-bit code width, three channels, and extra control delays of one and two clocks for the two 4:2:2 formats. With them, the mid-scale blanking code 512 and both non-zero control delays can be observed at the ports. The scoreboard keeps a history of the applied controls. Each expected item is taken from the history entry that matches the current format's delay, so format switches while data is running are checked at the cycle where the old and new delays overlap. Tri-level windows are checked with sync both on channel 0 only and on all channels.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

  // Colour-space / input format, as presented by the demultiplexer
  typedef enum logic [1:0] {
    FMT_GBR444      = 2'b00,
    FMT_YCC444      = 2'b01,
    FMT_YCC422_DUAL = 2'b10,
    FMT_YCC422_ONE  = 2'b11
  } fmt_e;

  // Level tag handed to the analog stage
  typedef enum logic [1:0] {
    LVL_VIDEO    = 2'b00,
    LVL_BLANK    = 2'b01,
    LVL_SYNC_NEG = 2'b10,
    LVL_SYNC_POS = 2'b11
  } lvl_e;

  // Controls, already converted to active high
  typedef struct packed {
    logic sync;
    logic blank;
    logic pos;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sync: 1'b0, blank: 1'b1, pos: 1'b0};

endpackage

// File: rtl/sbi_ctl_skew.sv
// Control delay line: registers the controls, then picks the tap that
// matches the extra data latency of the current format.
module sbi_ctl_skew
  import sbi_pkg::*;
#(
  parameter int MAX_SKEW    = 2,
  parameter int SKEW_DUAL   = 1,
  parameter int SKEW_SINGLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl_in,
  input  fmt_e fmt,
  output ctl_t ctl_out
);

  localparam int DEPTH = MAX_SKEW + 1;

  ctl_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= CTL_IDLE;
    else     stage_q[0] <= ctl_in;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[k] <= CTL_IDLE;
      else     stage_q[k] <= stage_q[k-1];
    end
  end

  always_comb begin
    case (fmt)
      FMT_YCC422_DUAL: ctl_out = stage_q[SKEW_DUAL];
      FMT_YCC422_ONE:  ctl_out = stage_q[SKEW_SINGLE];
      default:         ctl_out = stage_q[0];
    endcase
  end

endmodule

// File: rtl/sbi_lane.sv
// One output channel: chooses video, blank or sync and registers the result.
module sbi_lane
  import sbi_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LANE      = 0,
  parameter int SYNC_LANE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix,
  input  fmt_e              fmt,
  input  logic              ins_all,
  input  ctl_t              ctl,
  output logic [DATA_W-1:0] code,
  output lvl_e              tag
);

  localparam logic [DATA_W-1:0] MID_CODE     = {1'b1, {(DATA_W-1){1'b0}}};
  localparam bit                IS_SYNC_LANE = (LANE == SYNC_LANE);

  logic [DATA_W-1:0] blank_lvl;
  logic              carries_sync;
  logic [DATA_W-1:0] code_d;
  lvl_e              tag_d;

  // Chroma channels sit at mid-scale only when sync goes on all channels
  always_comb begin
    if (fmt != FMT_GBR444 && ins_all && !IS_SYNC_LANE) blank_lvl = MID_CODE;
    else                                                blank_lvl = '0;
  end

  assign carries_sync = ctl.sync && (ins_all || IS_SYNC_LANE);

  always_comb begin
    if (carries_sync) begin
      tag_d  = ctl.pos ? LVL_SYNC_POS : LVL_SYNC_NEG;
      code_d = blank_lvl;
    end else if (ctl.sync || ctl.blank) begin
      tag_d  = LVL_BLANK;
      code_d = blank_lvl;
    end else begin
      tag_d  = LVL_VIDEO;
      code_d = pix;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      tag  <= LVL_BLANK;
    end else begin
      code <= code_d;
      tag  <= tag_d;
    end
  end

endmodule

// File: rtl/sync_blank_inserter.sv
module sync_blank_inserter
  import sbi_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DATA_W      = 10,
  parameter int SYNC_LANE   = 0,
  parameter int SKEW_DUAL   = 1,
  parameter int SKEW_SINGLE = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH*DATA_W-1:0] pix_in,
  input  logic                     sync_n,
  input  logic                     blank_n,
  input  logic                     sync_pos,
  input  logic [1:0]               fmt,
  input  logic                     ins_all,
  output logic [NUM_CH*DATA_W-1:0] code_out,
  output logic [NUM_CH*2-1:0]      tag_out
);

  localparam int MAX_SKEW = (SKEW_DUAL > SKEW_SINGLE) ? SKEW_DUAL : SKEW_SINGLE;

  logic [NUM_CH*DATA_W-1:0] pix_q;
  fmt_e                     fmt_q;
  logic                     ins_q;
  ctl_t                     ctl_raw;
  ctl_t                     ctl_al;

  // Format and flag travel with the data sample
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
      fmt_q <= FMT_GBR444;
      ins_q <= 1'b0;
    end else begin
      pix_q <= pix_in;
      fmt_q <= fmt_e'(fmt);
      ins_q <= ins_all;
    end
  end

  assign ctl_raw = '{sync: ~sync_n, blank: ~blank_n, pos: sync_pos};

  sbi_ctl_skew #(
    .MAX_SKEW   (MAX_SKEW),
    .SKEW_DUAL  (SKEW_DUAL),
    .SKEW_SINGLE(SKEW_SINGLE)
  ) u_skew (
    .clk    (clk),
    .rst    (rst),
    .ctl_in (ctl_raw),
    .fmt    (fmt_q),
    .ctl_out(ctl_al)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    lvl_e lane_tag;

    sbi_lane #(
      .DATA_W   (DATA_W),
      .LANE     (i),
      .SYNC_LANE(SYNC_LANE)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .pix    (pix_q[i*DATA_W +: DATA_W]),
      .fmt    (fmt_q),
      .ins_all(ins_q),
      .ctl    (ctl_al),
      .code   (code_out[i*DATA_W +: DATA_W]),
      .tag    (lane_tag)
    );

    assign tag_out[2*i +: 2] = lane_tag;
  end

endmodule

// File: rtl/sync_blank_inserter_chk.sv
module sync_blank_inserter_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH*DATA_W-1:0] pix_in,
  input logic                     sync_n,
  input logic                     sync_pos,
  input logic [1:0]               fmt,
  input logic                     ins_all,
  input logic [NUM_CH*DATA_W-1:0] code_out,
  input logic [NUM_CH*2-1:0]      tag_out
);

  // R1: reset forces blank on every channel
  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (code_out == '0 && tag_out == {NUM_CH{2'b01}}));

  // R4: in the 4:4:4 formats a sync window two clocks back drives a sync tag on channel 0
  p_sync_luma_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(sync_n, 2) && !$past(fmt[1], 2))
      |-> tag_out[1]);

  // R5: polarity follows the strobe
  p_sync_polarity_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(sync_n, 2) && !$past(fmt[1], 2))
      |-> (tag_out[0] == $past(sync_pos, 2)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2: a video tag passes the pixel code from two clocks back
    p_video_pass_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && tag_out[2*i +: 2] == 2'b00)
        |-> (code_out[i*DATA_W +: DATA_W] == $past(pix_in[i*DATA_W +: DATA_W], 2)));

    // R8: GBR blanking and sync sit at code 0
    p_gbr_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && $past(fmt, 2) == 2'b00 && tag_out[2*i +: 2] != 2'b00)
        |-> (code_out[i*DATA_W +: DATA_W] == '0));

    if (i != 0) begin : g_chroma
      // R6: chroma channels never carry sync when the flag is low
      p_luma_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && !$past(ins_all, 2)) |-> !tag_out[2*i+1]);

      // R7: with the flag high all channels share the sync tag
      p_all_same_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && $past(ins_all, 2) && tag_out[1])
          |-> (tag_out[2*i +: 2] == tag_out[1:0]));
    end
  end

endmodule

bind sync_blank_inserter sync_blank_inserter_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pix_in  (pix_in),
  .sync_n  (sync_n),
  .sync_pos(sync_pos),
  .fmt     (fmt),
  .ins_all (ins_all),
  .code_out(code_out),
  .tag_out (tag_out)
);

// File: tb/sync_blank_inserter_tb.sv
`timescale 1ns/1ps
module sync_blank_inserter_tb;

  localparam int NCH  = 3;
  localparam int DW   = 10;
  localparam int HMAX = 4096;

  logic            clk = 1'b0;
  logic            rst;
  logic [NCH*DW-1:0] pix_in;
  logic            sync_n, blank_n, sync_pos, ins_all;
  logic [1:0]      fmt;
  logic [NCH*DW-1:0] code_out;
  logic [NCH*2-1:0]  tag_out;

  always #2.5 clk = ~clk;

  sync_blank_inserter u_dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .sync_n(sync_n), .blank_n(blank_n),
    .sync_pos(sync_pos), .fmt(fmt), .ins_all(ins_all),
    .code_out(code_out), .tag_out(tag_out)
  );

  typedef struct {
    int               due;
    logic [NCH*DW-1:0] code;
    logic [NCH*2-1:0]  tag;
    string            req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  int   seq = 0;
  bit   h_sync [HMAX];
  bit   h_blank[HMAX];
  bit   h_pos  [HMAX];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs with the expected item due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (code_out !== e.code || tag_out !== e.tag) begin
        failures++;
        $display("FAIL %s: cycle %0d code=%h tag=%b expected code=%h tag=%b",
                 e.req, cyc, code_out, tag_out, e.code, e.tag);
      end
    end
  end

  // Driver: apply one clock of stimulus and push the expected result
  task automatic step(input bit s_n, input bit b_n, input bit sp,
                      input logic [1:0] f, input bit ins, input string req);
    exp_t e;
    int   p, k, idx;
    bit   cs, cb, cp;
    logic [NCH*DW-1:0] px;
    @(negedge clk);
    p   = cyc;
    px  = {DW'(seq*13 + 700), DW'(seq*91 + 300), DW'(seq*37 + 5)};
    seq++;
    pix_in = px; sync_n = s_n; blank_n = b_n; sync_pos = sp; fmt = f; ins_all = ins;
    h_sync[p] = !s_n; h_blank[p] = !b_n; h_pos[p] = sp;
    k   = (f == 2'b10) ? 1 : (f == 2'b11) ? 2 : 0;  // R10 control delay
    idx = p - k;
    cs = h_sync[idx]; cb = h_blank[idx]; cp = h_pos[idx];
    for (int i = 0; i < NCH; i++) begin
      logic [DW-1:0] bl;
      bl = (f != 2'b00 && ins && i != 0) ? DW'(512) : DW'(0);  // R8 R9
      if (cs && (ins || i == 0)) begin
        e.tag[2*i +: 2]   = cp ? 2'b11 : 2'b10;
        e.code[i*DW +: DW] = bl;
      end else if (cs || cb) begin
        e.tag[2*i +: 2]   = 2'b01;
        e.code[i*DW +: DW] = bl;
      end else begin
        e.tag[2*i +: 2]   = 2'b00;
        e.code[i*DW +: DW] = px[i*DW +: DW];
      end
    end
    e.due = p + 2;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < HMAX; i++) begin h_sync[i] = 0; h_blank[i] = 1; h_pos[i] = 0; end
    rst = 1'b1; pix_in = '0; sync_n = 1'b1; blank_n = 1'b0; sync_pos = 1'b0;
    fmt = 2'b00; ins_all = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (code_out !== '0 || tag_out !== 6'b010101) begin
      failures++;
      $display("FAIL R1: code=%h tag=%b expected code=0 tag=010101", code_out, tag_out);
    end
    rst = 1'b0;

    // GBR, luma-only sync
    for (int i = 0; i < 4; i++) step(1, 1, 0, 2'b00, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 2'b00, 0, "R5 strobe ignored");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'b00, 0, "R3 R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b00, 0, "R4 R6");
    for (int i = 0; i < 2; i++) step(0, 1, 1, 2'b00, 0, "R5 R6");
    for (int i = 0; i < 2; i++) step(1, 1, 0, 2'b00, 1, "R2");
    for (int i = 0; i < 2; i++) step(0, 1, 0, 2'b00, 1, "R7 R8");

    // YPbPr 4:4:4, sync on all channels, tri-level window
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'b01, 1, "R9 R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b01, 1, "R4 R7");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 2'b01, 1, "R5 R7 tri-level");
    for (int i = 0; i < 2; i++) step(1, 1, 0, 2'b01, 1, "R2");
    // YPbPr with flag low: blank code 0 everywhere
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'b01, 0, "R9");
    for (int i = 0; i < 2; i++) step(0, 1, 1, 2'b01, 0, "R6 R9");

    // 4:2:2 dual-port: one-clock control delay
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b10, 1, "R10");
    step(1, 0, 0, 2'b10, 1, "R10");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b10, 1, "R10");
    step(0, 1, 0, 2'b10, 1, "R10");
    step(0, 1, 1, 2'b10, 1, "R10 R5");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b10, 1, "R10");

    // 4:2:2 single-port: two-clock control delay
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b11, 1, "R10");
    step(1, 0, 0, 2'b11, 1, "R10");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b11, 1, "R10");
    step(0, 0, 0, 2'b11, 0, "R10 R6");
    step(0, 1, 1, 2'b11, 0, "R10 R5");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 2'b11, 0, "R10 R2");
    // Back to 4:4:4 while data is running
    for (int i = 0; i < 3; i++) step(1, 1, 0, 2'b00, 0, "R10 R2");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule